// File: doc/BRIEF.md
# Low-Weight Single-Error-Correcting Codec for 8-bit Words

This block protects an 8-bit memory word with five check bits. Its encoding path turns a data byte into the five check bits that are stored beside it. Its decoding path takes a 13-bit word read back from storage and recomputes the check bits from the data half. It XORs them with the stored check bits to form a 5-bit syndrome, and repairs a single corrupted data bit. Both paths are purely combinational and independent of each other, so the encoder sits on the write port and the decoder on the read port of the same array.

Every data column of the check matrix has at most two ones, so each data bit is repaired by a two-input AND of syndrome bits rather than a full syndrome decode. Data bit M7 is covered only by check bit P5. Its single-one column is told apart from the M4 case by an inverted C1 term. Because that column coincides with the column of P5 itself, a lone syndrome bit C5 is always treated as an M7 upset. A syndrome that matches no column leaves the data untouched and raises a flag. Double errors are not guaranteed to be detected.

Top module: `secc_codec`

## Requirements
- R1: The encoder computes, with data bit Mk on data_in[k-1]: check_out[0]=M1^M2^M3^M4, check_out[1]=M1^M5^M6, check_out[2]=M2^M5^M8, check_out[3]=M3^M6^M8, check_out[4]=M4^M7.
- R2: The read word carries M8..M1 in code_in[7:0] and the stored check bit Pi in code_in[7+i]. The syndrome bit syndrome[i-1] is Ci, the R1 check bit i recomputed from code_in[7:0] XOR the stored Pi.
- R3: A read word whose stored check bits equal the R1 encoding of its data gives syndrome 0, all four flags low, and data_out equal to code_in[7:0].
- R4: A single inverted data bit of a valid word is restored in data_out, and data_corrected is 1. The syndrome equals that bit's column: M1 00011, M2 00101, M3 01001, M4 10001, M5 00110, M6 01010, M7 10000, M8 01100 (written C5..C1). No other data bit changes.
- R5: A single inverted stored check bit P1..P4 sets only the matching syndrome bit and raises check_err, and data_out equals the original data.
- R6: A single inverted stored P5 gives syndrome 10000, which is read as an M7 upset: data_out equals the original data with bit 6 inverted, and data_corrected is 1.
- R7: A nonzero syndrome that is neither a data column from R4 nor a single bit among C1..C4 raises uncorrectable, and data_out equals code_in[7:0].
- R8: err_detected is 1 exactly when the syndrome is nonzero, and at most one of data_corrected, check_err and uncorrectable is 1.
- R9: Data 0xAA encodes to check_out 5'b10010; flipping its bit 0 on read gives syndrome 5'b00011 and data_out 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 8 | Byte to encode, M1 on bit 0 |
| check_out | output | 5 | Check bits for data_in, P1 on bit 0 |
| code_in | input | 13 | Word read from storage: data in 7:0, P1..P5 in 12:8 |
| data_out | output | 8 | Data after single-bit repair |
| syndrome | output | 5 | Correction bits C5..C1 |
| err_detected | output | 1 | Syndrome is nonzero |
| data_corrected | output | 1 | A data bit was inverted |
| check_err | output | 1 | Only one of C1..C4 is set; data kept |
| uncorrectable | output | 1 | Syndrome matches no column; data kept |

## Verification
The immediate assertions in the design only evaluate when code_in carries no unknown bits. They take for granted that a repaired word, once re-encoded, always matches the stored check bits, whatever error pattern produced the syndrome. The bench drives only fully defined words: every byte with no upset and with each of the 13 single flips, and for one byte every pair of flipped positions. Its expected outputs come from a column table it builds on its own, which covers the P5/M7 aliasing and the syndromes that match no column.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 5;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int M7_IDX = 6;

  // Check bit equations, P1 on bit 0
  function automatic logic [CHK_W-1:0] secc_checks(input logic [DATA_W-1:0] m);
    logic [CHK_W-1:0] p;
    p[0] = (m[0] ^ m[1]) ^ (m[2] ^ m[3]);
    p[1] = (m[0] ^ m[4]) ^ m[5];
    p[2] = (m[1] ^ m[4]) ^ m[7];
    p[3] = (m[2] ^ m[5]) ^ m[7];
    p[4] = m[3] ^ m[6];
    return p;
  endfunction

  // Pairwise AND network; M7 uses the inverted C1 term
  function automatic logic [DATA_W-1:0] secc_flip_terms(input logic [CHK_W-1:0] c);
    logic [DATA_W-1:0] f;
    f[0] = c[0] & c[1];
    f[1] = c[0] & c[2];
    f[2] = c[0] & c[3];
    f[3] = c[0] & c[4];
    f[4] = c[1] & c[2];
    f[5] = c[1] & c[3];
    f[6] = ~c[0] & c[4];
    f[7] = c[2] & c[3];
    return f;
  endfunction
endpackage

// File: rtl/secc_encoder.sv
module secc_encoder
  import secc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  always_comb check = secc_checks(data);
endmodule

// File: rtl/secc_syndrome.sv
module secc_syndrome
  import secc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  syn
);
  logic [CHK_W-1:0] stored_chk;
  logic [CHK_W-1:0] recomputed_chk;

  always_comb begin
    rd_data        = code[DATA_W-1:0];
    stored_chk     = code[CODE_W-1:DATA_W];
    recomputed_chk = secc_checks(rd_data);
    syn            = recomputed_chk ^ stored_chk;
  end
endmodule

// File: rtl/secc_corrector.sv
module secc_corrector
  import secc_pkg::*;
(
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] fixed_data,
  output logic              data_hit,
  output logic              check_hit,
  output logic              no_match
);
  logic [DATA_W-1:0] raw_terms;
  logic [DATA_W-1:0] applied;
  logic [2:0]        syn_weight;
  logic [2:0]        want_weight;

  always_comb begin
    raw_terms   = secc_flip_terms(syn);
    syn_weight  = 3'($countones(syn));
    want_weight = raw_terms[M7_IDX] ? 3'd1 : 3'd2;
    data_hit    = $onehot(raw_terms) && (syn_weight == want_weight);
    check_hit   = $onehot(syn) && !syn[CHK_W-1];
    no_match    = (|syn) && !data_hit && !check_hit;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_fix
      assign applied[gi]    = raw_terms[gi] & data_hit;
      assign fixed_data[gi] = rd_data[gi] ^ applied[gi];
    end
  endgenerate

  always_comb begin
    if (!$isunknown(syn)) begin
      AST_APPLIED_SINGLE: assert (!data_hit || $onehot(applied)) else $error("mask not single"); // R4
      AST_NONE_APPLIED: assert (data_hit || applied == '0) else $error("mask without hit"); // R7
    end
  end
endmodule

// File: rtl/secc_codec.sv
module secc_codec
  import secc_pkg::*;
(
  input  logic [7:0]  data_in,
  output logic [4:0]  check_out,
  input  logic [12:0] code_in,
  output logic [7:0]  data_out,
  output logic [4:0]  syndrome,
  output logic        err_detected,
  output logic        data_corrected,
  output logic        check_err,
  output logic        uncorrectable
);
  logic [DATA_W-1:0] rd_data;
  logic [CHK_W-1:0]  syn_w;
  logic              hit_data;
  logic              hit_check;
  logic              hit_none;

  secc_encoder u_enc (
    .data  (data_in),
    .check (check_out)
  );

  secc_syndrome u_syn (
    .code    (code_in),
    .rd_data (rd_data),
    .syn     (syn_w)
  );

  secc_corrector u_fix (
    .rd_data    (rd_data),
    .syn        (syn_w),
    .fixed_data (data_out),
    .data_hit   (hit_data),
    .check_hit  (hit_check),
    .no_match   (hit_none)
  );

  always_comb begin
    syndrome       = syn_w;
    err_detected   = |syn_w;
    data_corrected = hit_data;
    check_err      = hit_check;
    uncorrectable  = hit_none;
  end

  always_comb begin
    if (!$isunknown(code_in)) begin
      AST_FLAGS_EXCLUSIVE: assert ($onehot0({data_corrected, check_err, uncorrectable})) else $error("flags overlap"); // R8
      AST_ERR_COVERS: assert (err_detected == (data_corrected | check_err | uncorrectable)) else $error("err flag mismatch"); // R8
      AST_ONE_BIT_CHANGE: assert ($countones(data_out ^ code_in[DATA_W-1:0]) <= 1) else $error("multi-bit change"); // R4
      AST_REPAIR_CONSISTENT: assert (!data_corrected || secc_checks(data_out) == code_in[CODE_W-1:DATA_W]) else $error("repair inconsistent"); // R4
      AST_CHECK_KEEPS_DATA: assert (!check_err || data_out == code_in[DATA_W-1:0]) else $error("check error touched data"); // R5
      AST_PASS_THROUGH: assert (data_corrected || data_out == code_in[DATA_W-1:0]) else $error("data altered"); // R7
    end
  end
endmodule

// File: tb/sim_secc_codec.sv
module sim_secc_codec;
  logic        clk = 1'b0;
  logic [7:0]  data_in = '0;
  logic [12:0] code_in = '0;
  logic [7:0]  data_out;
  logic [4:0]  check_out, syndrome;
  logic        err_detected, data_corrected, check_err, uncorrectable;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  secc_codec u0 (
    .data_in(data_in), .check_out(check_out), .code_in(code_in),
    .data_out(data_out), .syndrome(syndrome), .err_detected(err_detected),
    .data_corrected(data_corrected), .check_err(check_err),
    .uncorrectable(uncorrectable)
  );

  // Column of each codeword position, C5..C1
  function automatic logic [4:0] col(input int pos);
    case (pos)
      0: return 5'b00011;
      1: return 5'b00101;
      2: return 5'b01001;
      3: return 5'b10001;
      4: return 5'b00110;
      5: return 5'b01010;
      6: return 5'b10000;
      7: return 5'b01100;
      default: return 5'(1 << (pos - 8));
    endcase
  endfunction

  function automatic logic [4:0] ref_checks(input logic [7:0] d);
    logic [4:0] r = '0;
    for (int i = 0; i < 8; i++) if (d[i]) r ^= col(i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [12:0] code);
    @(posedge clk);
    data_in = d;
    code_in = code;
    @(negedge clk);
  endtask

  // Full decode check against the bench's own column model
  task automatic expect_decode(input string tag);
    logic [4:0] syn_e;
    logic [7:0] dat_e;
    logic [3:0] flg_e;
    int dpos;
    bit cor, chke, unc;
    syn_e = ref_checks(code_in[7:0]) ^ code_in[12:8];
    dpos = -1;
    for (int i = 0; i < 8; i++) if (col(i) == syn_e) dpos = i;
    dat_e = code_in[7:0];
    if (dpos >= 0) dat_e[dpos] = ~dat_e[dpos];
    cor  = (dpos >= 0);
    chke = !cor && $onehot(syn_e);
    unc  = (syn_e != 0) && !cor && !chke;
    flg_e = {syn_e != 0, cor, chke, unc};
    chk(syndrome == syn_e, {tag, " syndrome R2"}, 32'(syndrome), 32'(syn_e));
    chk(data_out == dat_e, {tag, " data R8"}, 32'(data_out), 32'(dat_e));
    chk({err_detected, data_corrected, check_err, uncorrectable} == flg_e,
        {tag, " flags R8"}, 32'({err_detected, data_corrected, check_err, uncorrectable}), 32'(flg_e));
  endtask

  task automatic t_idle_state;
    apply(8'h00, 13'h0000);
    chk(check_out == 5'b0, "R1 zero data", 32'(check_out), 0);
    chk({err_detected, data_corrected, check_err, uncorrectable} == 4'b0, "R3 zero word flags",
        32'({err_detected, data_corrected, check_err, uncorrectable}), 0);
  endtask

  task automatic t_worked_vector;
    apply(8'hAA, {5'b10010, 8'hAB});
    chk(check_out == 5'b10010, "R9 encode", 32'(check_out), 32'h12);
    chk(syndrome == 5'b00011, "R9 syndrome", 32'(syndrome), 32'h03);
    chk(data_out == 8'hAA, "R9 data", 32'(data_out), 32'hAA);
  endtask

  task automatic t_exhaustive;
    for (int d = 0; d < 256; d++) begin
      logic [12:0] good;
      good = {ref_checks(8'(d)), 8'(d)};
      apply(8'(d), good);
      chk(check_out == good[12:8], "R1 encode", 32'(check_out), 32'(good[12:8]));
      chk(syndrome == 5'b0 && data_out == 8'(d) && !err_detected, "R3 clean", 32'(data_out), 32'(d));
      for (int p = 0; p < 13; p++) begin
        logic [12:0] bad;
        bad = good ^ 13'(1 << p);
        apply(8'(d), bad);
        expect_decode("single flip");
        if (p < 8)
          chk(data_out == 8'(d) && data_corrected && syndrome == col(p), "R4 data restored",
              32'(data_out), 32'(d));
        else if (p < 12)
          chk(data_out == 8'(d) && check_err && syndrome == col(p), "R5 check only",
              32'(data_out), 32'(d));
        else
          chk(data_out == (8'(d) ^ 8'h40) && data_corrected && syndrome == 5'b10000,
              "R6 P5 read as M7", 32'(data_out), 32'(8'(d) ^ 8'h40));
      end
    end
  endtask

  task automatic t_double_flips;
    logic [12:0] good;
    good = {ref_checks(8'h5A), 8'h5A};
    for (int a = 0; a < 13; a++)
      for (int b = a + 1; b < 13; b++) begin
        apply(8'h5A, good ^ 13'(1 << a) ^ 13'(1 << b));
        expect_decode("double flip R7");
      end
    // M1+M8 gives 01111: matches no column
    apply(8'h5A, good ^ 13'h081);
    chk(uncorrectable && data_out == (8'h5A ^ 8'h81), "R7 pass-through", 32'(data_out), 32'(8'h5A ^ 8'h81));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_idle_state();
    t_worked_vector();
    t_exhaustive();
    t_double_flips();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule